// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block sequences the response of a multi-phase PWM power controller to overcurrent faults. It watches a comparator flag that reports an overcurrent, and a flag that reports a reference-voltage step in progress. It drives an output-enable for each phase. Deasserting an enable puts that phase's PWM pin in high impedance. When a fault is seen, every phase is released in the same cycle. The block then counts a fixed number of switching-cycle ticks and requests a fresh soft-start.

Only a bounded number of soft-start attempts may fail. Once that budget is spent, the block locks off and stays off until it is disabled or a power-on reset arrives. A soft-start that finishes cleanly returns the block to normal operation, raises power-good and refills the attempt budget. While the reference is stepping, the comparator is masked, so the surge of capacitor current during the step cannot cause a trip.

Top module: `oc_hiccup_ctrl`

## Requirements
- R1: During and after synchronous reset (rst high), all phase enables, power-good, the latched-off flag and the soft-start request are 0.
- R2: With en_i=1 and por_i=0, an idle block enters soft-start on the next clock. ss_start_o is 1 for exactly the first cycle of every soft-start, and all phase enables are 1 while soft-start runs without a fault.
- R3: oc_raw_i passes through two flops before use. On the cycle the synchronized fault is first seen in soft-start or normal run, every bit of phase_oe_o is 0. On a fault in normal run, power-good is still 1 in that cycle.
- R4: After a fault, the block waits exactly WAIT_TICKS cycles in which tick_i=1 before it starts the next soft-start. Cycles with tick_i=0 do not advance the wait. With tick_i held at 1, ss_start_o rises WAIT_TICKS+1 clocks after the cycle in which the enables dropped.
- R5: A fault during soft-start aborts that attempt, counts it as failed and starts a new wait. A fault in normal run starts a wait without counting a failure.
- R6: The eighth consecutive failed soft-start (MAX_TRIES=8) makes latched_o 1 instead of starting another wait. From a clean start with the fault held, exactly 8 soft-start requests occur before the lock.
- R7: While locked off, the block ignores the fault input and ticks and issues no soft-start. It leaves the lock only when en_i is 0 or por_i is 1, returning to idle.
- R8: ss_done_i=1 during a fault-free soft-start cycle moves the block to normal run, sets pgood_o to 1 and clears the failed-attempt count, so a later run of faults again gets the full 8 attempts.
- R9: While ref_moving_i=1, the synchronized fault is ignored: enables stay 1 and power-good stays 1 in normal run.
- R10: pgood_o is 1 only in normal run. en_i=0 or por_i=1 returns the block to idle on the next clock, with power-good 0, the enables 0 and the attempt count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable level |
| por_i | input | 1 | Power-on-reset indication, active high |
| tick_i | input | 1 | One-cycle pulse per switching cycle |
| oc_raw_i | input | 1 | Asynchronous overcurrent comparator flag |
| ss_done_i | input | 1 | Soft-start ramp finished |
| ref_moving_i | input | 1 | Reference transition in progress; masks faults |
| phase_oe_o | output | PHASES | Per-phase PWM drive enable; 0 means high impedance |
| ss_start_o | output | 1 | One-cycle soft-start request |
| pgood_o | output | 1 | Power-good, high only in normal run |
| latched_o | output | 1 | Locked off after exhausted retries |

## Verification
A wrong attempt count shows up only late: the lock arrives after the wrong number of soft-start requests, or a run of faults after a clean start locks too early. For that reason the bench counts request pulses up to the lock on every path. A wrong wait counter shifts the first request after a fault by whole tick periods, and this is visible within one wait window. A mistake in the state or the mask shows up within two clocks: an enable left high on a synchronized fault, power-good outside normal run, or a trip while the reference is moving.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SOFT = 3'd1,
        ST_RUN  = 3'd2,
        ST_WAIT = 3'd3,
        ST_LOCK = 3'd4
    } hic_state_e;

    localparam int unsigned SYNC_STAGES = 2;

    // States in which the phases are allowed to switch
    function automatic logic drives_phases(hic_state_e s);
        return (s == ST_SOFT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/hiccup_fault_sync.sv
module hiccup_fault_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hiccup_wait_timer.sv
module hiccup_wait_timer #(
    parameter int unsigned WAIT_TICKS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int unsigned CW = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = tick_i && (cnt_q == LAST);

    // R4
    wait_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4
    wait_tickless_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hiccup_attempt_ctr.sv
module hiccup_attempt_ctr #(
    parameter int unsigned MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned AW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [AW-1:0] TOP = AW'(MAX_TRIES - 1);

    logic [AW-1:0] fails_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            fails_q <= '0;
        else if (inc_i && fails_q != TOP)
            fails_q <= fails_q + 1'b1;
    end

    assign last_o = (fails_q == TOP);

    // R6
    fails_range_chk: assert property (@(posedge clk) disable iff (rst)
        fails_q <= TOP);

    // R8
    fails_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (fails_q == '0));
endmodule

// File: rtl/oc_hiccup_ctrl.sv
module oc_hiccup_ctrl
    import hiccup_pkg::*;
#(
    parameter int unsigned PHASES     = 4,
    parameter int unsigned WAIT_TICKS = 2048,
    parameter int unsigned MAX_TRIES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              por_i,
    input  logic              tick_i,
    input  logic              oc_raw_i,
    input  logic              ss_done_i,
    input  logic              ref_moving_i,
    output logic [PHASES-1:0] phase_oe_o,
    output logic              ss_start_o,
    output logic              pgood_o,
    output logic              latched_o
);
    hic_state_e state_q, state_d;
    logic oc_sync, oc_eff;
    logic wait_done, last_try;
    logic att_inc, att_clr;
    logic ss_start_q;
    logic go_idle;

    hiccup_fault_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (oc_raw_i),
        .sync_o  (oc_sync)
    );

    // Blanking applied after synchronization
    assign oc_eff  = oc_sync && !ref_moving_i;
    assign go_idle = !en_i || por_i;

    hiccup_wait_timer #(.WAIT_TICKS(WAIT_TICKS)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (state_q != ST_WAIT),
        .tick_i  (tick_i),
        .done_o  (wait_done)
    );

    hiccup_attempt_ctr #(.MAX_TRIES(MAX_TRIES)) tries_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (att_clr),
        .inc_i  (att_inc),
        .last_o (last_try)
    );

    always_comb begin
        state_d = state_q;
        att_inc = 1'b0;
        att_clr = 1'b0;
        if (go_idle) begin
            state_d = ST_IDLE;
            att_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_SOFT;
                ST_SOFT: begin
                    if (oc_eff) begin
                        if (last_try) state_d = ST_LOCK;
                        else begin
                            state_d = ST_WAIT;
                            att_inc = 1'b1;
                        end
                    end else if (ss_done_i) begin
                        state_d = ST_RUN;
                        att_clr = 1'b1;
                    end
                end
                ST_RUN:  if (oc_eff) state_d = ST_WAIT;
                ST_WAIT: if (wait_done) state_d = ST_SOFT;
                ST_LOCK: state_d = ST_LOCK;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ss_start_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ss_start_q <= (state_d == ST_SOFT) && (state_q != ST_SOFT);
        end
    end

    // Phases released in the very cycle the fault is seen
    assign phase_oe_o = {PHASES{drives_phases(state_q) && !oc_eff}};
    assign ss_start_o = ss_start_q;
    assign pgood_o    = (state_q == ST_RUN);
    assign latched_o  = (state_q == ST_LOCK);

    // R2
    ss_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        ss_start_o |=> !ss_start_o);

    // R3
    run_fault_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (pgood_o && oc_sync && !ref_moving_i) |=> !pgood_o);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (latched_o && en_i && !por_i) |=> (latched_o && !ss_start_o));

    // R10
    disable_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i || por_i) |=> (!pgood_o && !latched_o && phase_oe_o == '0));

    // R9
    blank_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        (pgood_o && ref_moving_i && en_i && !por_i) |=> pgood_o);
endmodule

// File: tb/oc_hiccup_ctrl_tb_top.sv
module oc_hiccup_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 3;
    localparam int W  = 16;
    localparam int MT = 8;
    localparam int LIMIT = 10 * W;
    localparam logic [PH-1:0] ALL_ON = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, por = 0, tick = 1, oc = 0, ssd = 0, refm = 0;
    logic [PH-1:0] oe;
    logic ss_start, pgood, latched;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_hiccup_ctrl #(.PHASES(PH), .WAIT_TICKS(W), .MAX_TRIES(MT)) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .por_i(por), .tick_i(tick),
        .oc_raw_i(oc), .ss_done_i(ssd), .ref_moving_i(refm),
        .phase_oe_o(oe), .ss_start_o(ss_start), .pgood_o(pgood),
        .latched_o(latched)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Cycles until a soft-start request is seen at a falling edge
    task automatic wait_ss(output int cyc);
        cyc = 0;
        do begin
            step();
            cyc++;
        end while (!ss_start && cyc < LIMIT);
    endtask

    // Request pulses counted until the lock, bounded
    task automatic count_to_lock(output int pulses);
        int n = 0;
        pulses = 0;
        while (!latched && n < MT * LIMIT) begin
            step();
            n++;
            if (ss_start) pulses++;
        end
    endtask

    task automatic finish_soft();
        ssd = 1'b1;
        step();
        ssd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        int pulses;
        bit bad;
        @(negedge clk);
        step();
        check(oe == '0 && !pgood && !latched && !ss_start, "R1 reset", oe, 0);
        rst = 1'b0;
        step();
        check(oe == '0 && !pgood && !ss_start, "R1 idle disabled", oe, 0);

        // R2: enable starts soft-start
        en = 1'b1;
        step();
        check(ss_start == 1'b1, "R2 ss pulse", ss_start, 1);
        check(oe == ALL_ON && !pgood, "R2 enables in soft", oe, ALL_ON);
        step();
        check(ss_start == 1'b0, "R2 pulse single", ss_start, 0);

        // R8: successful soft-start
        finish_soft();
        check(pgood == 1'b1, "R8 pgood", pgood, 1);
        check(oe == ALL_ON, "R8 enables in run", oe, ALL_ON);

        // R9: blanking during reference step
        refm = 1'b1;
        oc = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (oe != ALL_ON || !pgood) bad = 1;
        end
        check(!bad, "R9 blanked fault", bad, 0);
        oc = 1'b0;
        repeat (4) step();
        refm = 1'b0;
        step();
        check(pgood == 1'b1, "R9 still running", pgood, 1);

        // R3: synchronized fault latency and immediate release
        oc = 1'b1;
        step();
        check(oe == ALL_ON, "R3 first flop only", oe, ALL_ON);
        oc = 1'b0;
        step();
        check(oe == '0, "R3 enables drop", oe, 0);
        check(pgood == 1'b1, "R3 same cycle as run", pgood, 1);

        // R4: wait window with tick every cycle
        wait_ss(cyc);
        check(cyc == W + 1, "R4 wait length", cyc, W + 1);
        check(oe == ALL_ON, "R5 retry enables", oe, ALL_ON);
        finish_soft();
        check(pgood == 1'b1, "R8 back to run", pgood, 1);

        // R4: ticks, not clocks
        oc = 1'b1;
        step();
        oc = 1'b0;
        step();
        tick = 1'b0;
        bad = 0;
        for (int i = 0; i < 5 * W; i++) begin
            step();
            if (ss_start || pgood) bad = 1;
        end
        check(!bad, "R4 no ticks no retry", bad, 0);
        check(!pgood && oe == '0, "R10 pgood low in wait", pgood, 0);
        tick = 1'b1;
        wait_ss(cyc);
        check(cyc == W, "R4 tick-counted wait", cyc, W);
        finish_soft();

        // R5/R8: three failed attempts then success clears the count
        oc = 1'b1;
        for (int k = 0; k < 3; k++) wait_ss(cyc);
        oc = 1'b0;
        wait_ss(cyc);
        check(ss_start == 1'b1 && !latched, "R5 retry after aborts", ss_start, 1);
        finish_soft();
        check(pgood == 1'b1, "R8 success after aborts", pgood, 1);

        // R6: full budget after the clear
        oc = 1'b1;
        count_to_lock(pulses);
        check(latched == 1'b1, "R6 locked", latched, 1);
        check(pulses == MT, "R6/R8 attempts before lock", pulses, MT);
        check(oe == '0 && !pgood, "R6 outputs off in lock", oe, 0);

        // R7: lock holds without fault and with ticks
        oc = 1'b0;
        bad = 0;
        for (int i = 0; i < 3 * W; i++) begin
            step();
            if (!latched || ss_start || oe != '0) bad = 1;
        end
        check(!bad, "R7 lock holds", bad, 0);

        // R7: leave lock by power-on reset
        por = 1'b1;
        step();
        check(latched == 1'b0 && oe == '0, "R7 por releases", latched, 0);
        por = 1'b0;
        step();
        check(ss_start == 1'b1, "R2 restart after por", ss_start, 1);

        // R6 from a clean start, then R7 leave by enable
        oc = 1'b1;
        pulses = 1;
        begin
            int more;
            count_to_lock(more);
            pulses += more;
        end
        check(pulses == MT, "R6 clean-start attempts", pulses, MT);
        en = 1'b0;
        step();
        check(latched == 1'b0, "R7 enable releases", latched, 0);
        oc = 1'b0;
        repeat (3) step();
        en = 1'b1;
        step();
        check(ss_start == 1'b1, "R2 restart after enable", ss_start, 1);
        finish_soft();

        // R10: disable in run
        check(pgood == 1'b1, "R10 run before disable", pgood, 1);
        en = 1'b0;
        step();
        check(!pgood && oe == '0, "R10 disable leaves run", pgood, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule